// File: doc/BRIEF.md
# Cross-Device Port Isolation Table

This block holds one egress-permission mask for every pairing of a source switch device and a source port in a stacked switch fabric. When a frame comes in from another chip, forwarding logic looks up the mask for that frame's origin and gets back the set of local ports the frame may leave through.

Software reaches the table indirectly through two 16-bit registers. The staging register holds a mask value. The command register takes an opcode and a packed entry pointer, and it shows a busy flag that software polls. Three commands exist:

- store the staged mask into one entry;
- fetch one entry into the staging register;
- fill the whole table with ones, one entry per cycle.

Forwarding logic uses a separate lookup port. It takes a device number and a port number and returns the mask one cycle later.

Top module: `xdev_vlan_table`

## Requirements
- R1: After reset, busy is 0, the drop flag is 0, the staging register reads 0, and every entry reads as all ones through both the lookup port and a fetch command.
- R2: Command register layout:
  - bit 15 is busy, and it is read-only;
  - bits [13:12] hold the opcode: 1 is fill, 2 is store, 3 is fetch;
  - bits [8:0] hold the pointer, with bits [8:4] as the device and bits [3:0] as the port.
  
  The entry that a pointer selects is the same entry the lookup port returns for that device and port.
- R3: A store command raises busy in the cycle after it is written. Busy clears one cycle later, and by then the staged mask is committed to the selected entry.
- R4: A fetch command leaves the selected entry in the staging register by the time busy clears.
- R5: A fill command keeps busy set for exactly 512 cycles. Afterwards every entry reads as all ones.
- R6: The lookup port returns the selected entry's mask one clock after the device and port are presented.
- R7: While a fill is in progress, the lookup port returns all ones.
- R8: Only the low MASK_W bits (default 11) of a staged value are kept. The upper bits of the staging register always read as 0.
- R9: Writes to the staging register while busy is set are ignored.
- R10: A command written while busy is set is dropped and does not change the table. It sets a drop flag that stays set until reset.
- R11: A command with opcode 0 does nothing: busy stays clear and no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the staging register, 1 selects the command register |
| reg_wdata | input | 16 | Register write data |
| data_rd | output | 16 | Staging register read value |
| cmd_rd | output | 16 | Command register read value: busy, last opcode, last pointer |
| drop_err | output | 1 | Sticky flag for a dropped command |
| lk_dev | input | 5 | Lookup source device |
| lk_port | input | 4 | Lookup source port |
| lk_mask | output | 11 | Lookup result, valid one cycle after the request |

## Verification
Directed stores at swapped device/port pairs show whether the pointer fields are packed in the right order. Staging values with all 16 bits set show whether the mask is truncated correctly. Several hundred random store, fetch and lookup sequences with a fixed seed, compared against a bench-side table, separate correct indexing and write-back from stale or misrouted entries. A fill issued over a table that already holds data, with a lookup, a staging write and a second command pushed in while the fill is busy, tells apart:
- the fill duration;
- the forced-ones lookup;
- the ignored staging write;
- the dropped command.

// File: rtl/xvt_pkg.sv
package xvt_pkg;
   localparam int REG_W    = 16;
   localparam int BUSY_BIT = 15;
   localparam int OP_LSB   = 12;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_FILL  = 2'd1,
      OP_STORE = 2'd2,
      OP_FETCH = 2'd3
   } xvt_op_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SINGLE = 2'd1,
      ST_FILL   = 2'd2
   } xvt_state_e;
endpackage

// File: rtl/xvt_store.sv
module xvt_store #(
   parameter int PTR_W  = 9,
   parameter int MASK_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              clr_en,
   input  logic [PTR_W-1:0]  acc_idx,
   input  logic [MASK_W-1:0] wr_mask,
   output logic [MASK_W-1:0] rd_mask,
   input  logic [PTR_W-1:0]  lk_idx,
   input  logic              lk_force,
   output logic [MASK_W-1:0] lk_mask
);
   localparam int ENTRIES = 1 << PTR_W;

   // Mask storage carries no reset; a per-entry written flag chooses between it and all ones.
   logic [MASK_W-1:0] mem [ENTRIES];
   logic [ENTRIES-1:0] written_q;
   logic [MASK_W-1:0]  lk_q;

   always_ff @(posedge clk) begin
      if (wr_en) mem[acc_idx] <= wr_mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         written_q <= '0;
      end else if (wr_en) begin
         written_q[acc_idx] <= 1'b1;
      end else if (clr_en) begin
         written_q[acc_idx] <= 1'b0;
      end
   end

   assign rd_mask = written_q[acc_idx] ? mem[acc_idx] : '1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lk_q <= '1;
      end else if (lk_force || !written_q[lk_idx]) begin
         lk_q <= '1;
      end else begin
         lk_q <= mem[lk_idx];
      end
   end

   assign lk_mask = lk_q;

   AST_LK_FILL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      lk_force |=> (lk_mask == {MASK_W{1'b1}})); // R7
   AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && clr_en)); // R5
endmodule

// File: rtl/xvt_ctrl.sv
module xvt_ctrl
   import xvt_pkg::*;
#(
   parameter int PTR_W  = 9,
   parameter int MASK_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [REG_W-1:0]  reg_wdata,
   input  logic [MASK_W-1:0] rd_mask,
   output logic              busy,
   output xvt_op_e           op_q,
   output logic [PTR_W-1:0]  ptr_q,
   output logic [MASK_W-1:0] data_q,
   output logic              err_q,
   output logic              st_wr_en,
   output logic              st_clr_en,
   output logic [PTR_W-1:0]  st_idx,
   output logic              fill_active
);
   xvt_state_e       state_q;
   logic [PTR_W-1:0] fill_ptr_q;
   xvt_op_e          op_in;
   logic             cmd_wr, data_wr, accept, drop;
   logic             unused_wdata;

   assign unused_wdata = ^reg_wdata;
   assign cmd_wr  = reg_wr &&  reg_sel;
   assign data_wr = reg_wr && !reg_sel;
   assign op_in   = xvt_op_e'(reg_wdata[OP_LSB +: 2]);
   assign busy    = (state_q != ST_IDLE);
   assign accept  = cmd_wr && !busy && (op_in != OP_NONE);
   assign drop    = cmd_wr && busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         op_q       <= OP_NONE;
         ptr_q      <= '0;
         data_q     <= '0;
         fill_ptr_q <= '0;
         err_q      <= 1'b0;
      end else begin
         if (drop) err_q <= 1'b1;
         case (state_q)
            ST_IDLE: begin
               if (data_wr) data_q <= reg_wdata[MASK_W-1:0];
               if (accept) begin
                  op_q       <= op_in;
                  ptr_q      <= reg_wdata[PTR_W-1:0];
                  fill_ptr_q <= '0;
                  state_q    <= (op_in == OP_FILL) ? ST_FILL : ST_SINGLE;
               end
            end
            ST_SINGLE: begin
               if (op_q == OP_FETCH) data_q <= rd_mask;
               state_q <= ST_IDLE;
            end
            ST_FILL: begin
               fill_ptr_q <= fill_ptr_q + 1'b1;
               if (fill_ptr_q == {PTR_W{1'b1}}) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign st_wr_en    = (state_q == ST_SINGLE) && (op_q == OP_STORE);
   assign st_clr_en   = (state_q == ST_FILL);
   assign st_idx      = (state_q == ST_FILL) ? fill_ptr_q : ptr_q;
   assign fill_active = (state_q == ST_FILL);

   AST_CMD_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy); // R3
   AST_SINGLE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_q != OP_FILL) |=> !busy); // R4
   AST_DROP_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> err_q); // R10
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q); // R10
   AST_FILL_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      fill_active |=> $stable(data_q)); // R9
   AST_NOP_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !busy && op_in == OP_NONE) |=> !busy); // R11
endmodule

// File: rtl/xdev_vlan_table.sv
module xdev_vlan_table
   import xvt_pkg::*;
#(
   parameter int DEV_W  = 5,
   parameter int PORT_W = 4,
   parameter int MASK_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       data_rd,
   output logic [15:0]       cmd_rd,
   output logic              drop_err,
   input  logic [DEV_W-1:0]  lk_dev,
   input  logic [PORT_W-1:0] lk_port,
   output logic [MASK_W-1:0] lk_mask
);
   localparam int PTR_W = DEV_W + PORT_W;

   generate
      if (MASK_W < 1 || MASK_W > REG_W) begin : g_bad_mask
         $error("MASK_W must lie in 1..16");
      end
      if (PTR_W > OP_LSB) begin : g_bad_ptr
         $error("pointer overlaps opcode field");
      end
   endgenerate

   logic              busy, err_q, st_wr_en, st_clr_en, fill_active;
   xvt_op_e           op_q;
   logic [PTR_W-1:0]  ptr_q, st_idx;
   logic [MASK_W-1:0] data_q, rd_mask;

   xvt_ctrl #(.PTR_W(PTR_W), .MASK_W(MASK_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .rd_mask(rd_mask), .busy(busy), .op_q(op_q),
      .ptr_q(ptr_q), .data_q(data_q), .err_q(err_q), .st_wr_en(st_wr_en),
      .st_clr_en(st_clr_en), .st_idx(st_idx), .fill_active(fill_active)
   );

   xvt_store #(.PTR_W(PTR_W), .MASK_W(MASK_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(st_wr_en), .clr_en(st_clr_en),
      .acc_idx(st_idx), .wr_mask(data_q), .rd_mask(rd_mask),
      .lk_idx({lk_dev, lk_port}), .lk_force(fill_active), .lk_mask(lk_mask)
   );

   generate
      if (MASK_W < REG_W) begin : g_pad
         assign data_rd = {{(REG_W-MASK_W){1'b0}}, data_q};
      end else begin : g_full
         assign data_rd = data_q;
      end
   endgenerate

   always_comb begin
      cmd_rd               = '0;
      cmd_rd[BUSY_BIT]     = busy;
      cmd_rd[OP_LSB +: 2]  = op_q;
      cmd_rd[PTR_W-1:0]    = ptr_q;
   end

   assign drop_err = err_q;

   AST_DATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd >> MASK_W) == '0); // R8
endmodule

// File: tb/xdev_vlan_table_bench.sv
module xdev_vlan_table_bench;
   localparam logic [10:0] ONES = 11'h7FF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_sel = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] data_rd, cmd_rd;
   logic        drop_err;
   logic [4:0]  lk_dev = '0;
   logic [3:0]  lk_port = '0;
   logic [10:0] lk_mask;

   int compared = 0, mismatched = 0;
   int run = 0, last_run = 0;
   logic [10:0] exp_tab [512];

   always #2.5 clk = ~clk;

   xdev_vlan_table u_xdev_vlan_table (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .data_rd(data_rd), .cmd_rd(cmd_rd),
      .drop_err(drop_err), .lk_dev(lk_dev), .lk_port(lk_port), .lk_mask(lk_mask)
   );

   always @(negedge clk) begin
      if (cmd_rd[15]) run = run + 1;
      else if (run != 0) begin last_run = run; run = 0; end
   end

   function automatic logic [15:0] cmd_word(input logic [1:0] op, input logic [8:0] ptr);
      return {2'b00, op, 3'b000, ptr};
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put_reg(input logic sel, input logic [15:0] v);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic wait_idle();
      while (cmd_rd[15]) @(negedge clk);
   endtask

   task automatic lookup(input logic [8:0] ptr, output logic [10:0] m);
      @(negedge clk);
      {lk_dev, lk_port} = ptr;
      @(negedge clk);
      m = lk_mask;
   endtask

   task automatic store(input logic [8:0] ptr, input logic [15:0] v);
      put_reg(1'b0, v);
      put_reg(1'b1, cmd_word(2'd2, ptr));
      wait_idle();
      exp_tab[ptr] = v[10:0];
   endtask

   task automatic fetch(input logic [8:0] ptr, output logic [15:0] d);
      put_reg(1'b1, cmd_word(2'd3, ptr));
      wait_idle();
      d = data_rd;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      compared++; mismatched++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [10:0] m;
      logic [15:0] d;
      logic [8:0]  p;
      void'($urandom(32'd4242));
      for (int i = 0; i < 512; i++) exp_tab[i] = ONES;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 busy", {15'd0, cmd_rd[15]}, 16'd0);
      check("R1 drop", {15'd0, drop_err}, 16'd0);
      check("R1 data", data_rd, 16'd0);
      lookup(9'd0, m);   check("R1 lookup 0", {5'd0, m}, {5'd0, ONES});
      lookup(9'd511, m); check("R1 lookup 511", {5'd0, m}, {5'd0, ONES});
      fetch(9'd77, d);   check("R1 fetch", d, {5'd0, ONES});

      // R8 truncation
      put_reg(1'b0, 16'hFFFF);
      check("R8 upper zero", data_rd, 16'h07FF);
      put_reg(1'b0, 16'hA123);
      check("R8 truncate", data_rd, 16'h0123);

      // R3 store timing
      put_reg(1'b1, cmd_word(2'd2, {5'd7, 4'd9}));
      check("R3 busy set", {15'd0, cmd_rd[15]}, 16'd1);
      check("R2 cmd fields", cmd_rd & 16'h31FF, 16'h2079);
      @(negedge clk);
      check("R3 busy clear", {15'd0, cmd_rd[15]}, 16'd0);
      exp_tab[{5'd7, 4'd9}] = 11'h123;

      // R6, R2 lookup and field order
      lookup({5'd7, 4'd9}, m); check("R6 lookup", {5'd0, m}, 16'h0123);
      lookup({5'd9, 4'd7}, m); check("R2 swapped", {5'd0, m}, {5'd0, ONES});

      // R4 fetch
      store({5'd31, 4'd15}, 16'h0555);
      put_reg(1'b0, 16'h0000);
      fetch({5'd31, 4'd15}, d); check("R4 fetch", d, 16'h0555);
      check("R3 store run", last_run[15:0], 16'd1);

      // R11 no-op command
      put_reg(1'b0, 16'h0011);
      put_reg(1'b1, cmd_word(2'd0, {5'd31, 4'd15}));
      check("R11 no busy", {15'd0, cmd_rd[15]}, 16'd0);
      lookup({5'd31, 4'd15}, m); check("R11 entry kept", {5'd0, m}, 16'h0555);

      // random store/fetch/lookup against the bench table
      for (int it = 0; it < 300; it++) begin
         p = 9'($urandom);
         store(p, 16'($urandom));
         p = 9'($urandom);
         lookup(p, m); check("R6 random lookup", {5'd0, m}, {5'd0, exp_tab[p]});
         if (it % 4 == 0) begin
            fetch(p, d); check("R4 random fetch", d, {5'd0, exp_tab[p]});
         end
      end

      // R5, R7, R9, R10 fill with intrusions
      store({5'd3, 4'd5}, 16'h0123);
      put_reg(1'b0, 16'h0321);
      put_reg(1'b1, cmd_word(2'd1, 9'd0));
      put_reg(1'b0, 16'h0055);
      check("R9 staging ignored", data_rd, 16'h0321);
      check("R10 no drop yet", {15'd0, drop_err}, 16'd0);
      put_reg(1'b1, cmd_word(2'd2, {5'd2, 4'd2}));
      check("R10 drop flag", {15'd0, drop_err}, 16'd1);
      lookup({5'd3, 4'd5}, m); check("R7 fill lookup", {5'd0, m}, {5'd0, ONES});
      wait_idle();
      @(negedge clk);
      check("R5 fill length", last_run[15:0], 16'd512);
      for (int i = 0; i < 512; i++) exp_tab[i] = ONES;
      lookup({5'd3, 4'd5}, m); check("R5 after fill", {5'd0, m}, {5'd0, ONES});
      lookup({5'd2, 4'd2}, m); check("R10 dropped store", {5'd0, m}, {5'd0, ONES});
      for (int k = 0; k < 20; k++) begin
         p = 9'($urandom);
         fetch(p, d); check("R5 fetch after fill", d, {5'd0, ONES});
      end
      check("R10 sticky", {15'd0, drop_err}, 16'd1);
      finish_run();
   end
endmodule